// File: doc/BRIEF.md
# Microcoded control sequencer

This block is the control unit of a small bus-based 8-bit processor. Each clock it combines the opcode held in the instruction register with a 4-bit micro-step counter and produces a 32-bit horizontal control word. Each bit of the word is one strobe in the datapath: bus drivers, register loads, memory access, ALU operation selects, output-register loads and jump-condition enables. A jump-condition bit only permits the program-counter load. The datapath evaluates the flags.

Every instruction starts with the same two fetch steps and then runs its own execute steps. No instruction has a fixed length. Each one ends with a step that carries the step-clear bit, and the counter then returns to step 0 to fetch again. The halt instruction carries the halt bit instead. That freezes the sequencer and silences the control word until the next reset. Opcodes 0x01 to 0x20 are defined. Every other opcode behaves as a no-operation.

Top module: `mcode_seq`

## Requirements
- R1: While rst_ni is low, step_o is 0 and halt_o is 0, and ctrl_o shows the first fetch word 0x90000000.
- R2: Whatever the opcode, step 0 gives ctrl_o = 0x90000000, which drives the PC onto the bus (bit 31) and loads the address register (bit 28). Step 1 gives 0x2C000000, which is memory read (bit 26), instruction-register load (bit 27) and PC increment (bit 29).
- R3: If the current word has neither bit 1 (step clear) nor bit 0 (halt), step_o rises by one at the next clock edge. If bit 1 is set and bit 0 is clear, step_o is 0 after the edge.
- R4: Each word drives the bus from at most one source. The sources are bit 31 (PC), bit 26 (memory), bit 24 (A), bit 22 (B) and the ALU selects, bits 20 down to 12.
- R5: Opcodes 0x02 to 0x08 (jumps) use step 2 = 0xB0000000, which is PC to bus, address load and PC increment. Step 3 = 0x44000002, which is memory read, PC load and step clear, ORed with one condition bit. Opcode 0x02 adds no condition bit, and opcode n from 0x03 to 0x08 adds bit 10-n.
- R6: Opcodes 0x09 to 0x0B load A and 0x0C to 0x0E load B. Within each group the three are immediate, direct and indirect. Step 2 = 0xB0000000. Then come 0, 1 or 2 steps of 0x14000000, which is memory read plus address load. The last step is 0x04000002 with bit 23 set for A or bit 21 set for B.
- R7: Opcodes 0x0F and 0x10 store A and 0x11 and 0x12 store B, direct then indirect. Step 2 = 0xB0000000. Then come 1 or 2 steps of 0x14000000. The last step is 0x02000002 (memory write and step clear) with bit 24 set for A or bit 22 set for B.
- R8: An ALU opcode n from 0x13 to 0x1B runs one execute step: bit 20-(n-0x13), A write (bit 23) and step clear, so 0x13 selects add (bit 20) and 0x1B selects shift right (bit 12). Compare (0x1C) runs a single step 0x00080002, which is subtract and step clear with no register load.
- R9: An output opcode n from 0x1D to 0x20 runs one execute step: A to bus (bit 24), output-register load bit 11-(n-0x1D), and step clear.
- R10: Opcode 0x01 gives step 2 = 0x00000001. After that edge, halt_o is 1, ctrl_o is 0 and step_o holds its value until reset.
- R11: Opcode 0x00 and opcodes 0x21 to 0xFF give step 2 = 0x00000002, which is step clear only, so the next fetch follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| opcode_i | input | 8 | Opcode from the instruction register |
| ctrl_o | output | 32 | Control word for the current micro-step |
| step_o | output | 4 | Current micro-step |
| halt_o | output | 1 | Sequencer halted |

## Verification
ctrl_o is combinational from step_o and opcode_i and is valid in the same cycle. step_o and halt_o respond one rising edge after the word that affects them. The bench changes reset and the opcode on falling edges and samples every output at the next falling edge. It compares the word for each step of every one of the 256 opcodes, then checks, one edge after the last step, that the counter has cleared or the sequencer has halted. After a halt it samples three more cycles to confirm that the frozen state holds.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int CW_W   = 32;
  localparam int OP_W   = 8;
  localparam int STEP_W = 4;

  localparam int B_PCR = 31;
  localparam int B_PCW = 30;
  localparam int B_PCI = 29;
  localparam int B_MAW = 28;
  localparam int B_IRW = 27;
  localparam int B_MMR = 26;
  localparam int B_MMW = 25;
  localparam int B_ARR = 24;
  localparam int B_ARW = 23;
  localparam int B_BRR = 22;
  localparam int B_BRW = 21;
  localparam int B_ADD = 20;
  localparam int B_SUB = 19;
  localparam int B_OAW = 11;
  localparam int B_JEQ = 7;
  localparam int B_RSC = 1;
  localparam int B_HLT = 0;

  typedef enum logic [2:0] {
    C_NOP, C_HALT, C_JUMP, C_LOAD, C_STORE, C_ALU, C_CMP, C_OUT
  } cls_e;

  typedef struct packed {
    cls_e       cls;
    logic [1:0] deref;  // memory-indirection steps before final
    logic       use_b;
    logic [3:0] idx;    // position within the opcode group
  } dec_t;
endpackage

// File: rtl/mseq_decode.sv
module mseq_decode
  import mseq_pkg::*;
#(
  parameter int OpW = OP_W
) (
  input  logic [OpW-1:0] opcode_i,
  output dec_t           dec_o
);
  logic [OpW-1:0] off;

  always_comb begin
    dec_o = '{cls: C_NOP, deref: 2'd0, use_b: 1'b0, idx: 4'd0};
    off   = '0;
    if (opcode_i == OpW'(8'h01)) begin
      dec_o.cls = C_HALT;
    end else if (opcode_i >= OpW'(8'h02) && opcode_i <= OpW'(8'h08)) begin
      off       = opcode_i - OpW'(8'h02);
      dec_o.cls = C_JUMP;
      dec_o.idx = off[3:0];
    end else if (opcode_i >= OpW'(8'h09) && opcode_i <= OpW'(8'h0e)) begin
      off         = opcode_i - OpW'(8'h09);
      dec_o.cls   = C_LOAD;
      dec_o.use_b = (off >= OpW'(3));
      dec_o.deref = dec_o.use_b ? 2'(off - OpW'(3)) : off[1:0];
    end else if (opcode_i >= OpW'(8'h0f) && opcode_i <= OpW'(8'h12)) begin
      off         = opcode_i - OpW'(8'h0f);
      dec_o.cls   = C_STORE;
      dec_o.use_b = off[1];
      dec_o.deref = off[0] ? 2'd2 : 2'd1;
    end else if (opcode_i >= OpW'(8'h13) && opcode_i <= OpW'(8'h1b)) begin
      off       = opcode_i - OpW'(8'h13);
      dec_o.cls = C_ALU;
      dec_o.idx = off[3:0];
    end else if (opcode_i == OpW'(8'h1c)) begin
      dec_o.cls = C_CMP;
    end else if (opcode_i >= OpW'(8'h1d) && opcode_i <= OpW'(8'h20)) begin
      off       = opcode_i - OpW'(8'h1d);
      dec_o.cls = C_OUT;
      dec_o.idx = off[3:0];
    end
  end
endmodule

// File: rtl/mseq_ucode.sv
module mseq_ucode
  import mseq_pkg::*;
#(
  parameter int StepW = STEP_W,
  parameter int CwW   = CW_W
) (
  input  dec_t             dec_i,
  input  logic [StepW-1:0] step_i,
  output logic [CwW-1:0]   cw_o
);
  localparam int DataLast = 2;  // first execute step

  int e;
  int last;

  always_comb begin
    cw_o = '0;
    e    = int'(step_i) - DataLast;
    last = int'(dec_i.deref) + 1;
    if (step_i == StepW'(0)) begin
      cw_o[B_PCR] = 1'b1;
      cw_o[B_MAW] = 1'b1;
    end else if (step_i == StepW'(1)) begin
      cw_o[B_MMR] = 1'b1;
      cw_o[B_IRW] = 1'b1;
      cw_o[B_PCI] = 1'b1;
    end else begin
      unique case (dec_i.cls)
        C_HALT: begin
          if (e == 0) cw_o[B_HLT] = 1'b1;
          else        cw_o[B_RSC] = 1'b1;
        end
        C_JUMP: begin
          if (e == 0) begin
            cw_o[B_PCR] = 1'b1; cw_o[B_MAW] = 1'b1; cw_o[B_PCI] = 1'b1;
          end else begin
            cw_o[B_RSC] = 1'b1;
            if (e == 1) begin
              cw_o[B_MMR] = 1'b1; cw_o[B_PCW] = 1'b1;
              if (dec_i.idx != 4'd0) cw_o[B_JEQ + 1 - int'(dec_i.idx)] = 1'b1;
            end
          end
        end
        C_LOAD, C_STORE: begin
          if (e == 0) begin
            cw_o[B_PCR] = 1'b1; cw_o[B_MAW] = 1'b1; cw_o[B_PCI] = 1'b1;
          end else if (e < last) begin
            cw_o[B_MMR] = 1'b1; cw_o[B_MAW] = 1'b1;
          end else begin
            cw_o[B_RSC] = 1'b1;
            if (e == last) begin
              if (dec_i.cls == C_LOAD) begin
                cw_o[B_MMR] = 1'b1;
                if (dec_i.use_b) cw_o[B_BRW] = 1'b1;
                else             cw_o[B_ARW] = 1'b1;
              end else begin
                cw_o[B_MMW] = 1'b1;
                if (dec_i.use_b) cw_o[B_BRR] = 1'b1;
                else             cw_o[B_ARR] = 1'b1;
              end
            end
          end
        end
        C_ALU: begin
          cw_o[B_RSC] = 1'b1;
          if (e == 0) begin
            cw_o[B_ADD - int'(dec_i.idx)] = 1'b1;
            cw_o[B_ARW] = 1'b1;
          end
        end
        C_CMP: begin
          cw_o[B_RSC] = 1'b1;
          if (e == 0) cw_o[B_SUB] = 1'b1;
        end
        C_OUT: begin
          cw_o[B_RSC] = 1'b1;
          if (e == 0) begin
            cw_o[B_ARR] = 1'b1;
            cw_o[B_OAW - int'(dec_i.idx)] = 1'b1;
          end
        end
        default: cw_o[B_RSC] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/mseq_step_ctr.sv
module mseq_step_ctr #(
  parameter int StepW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hlt_i,
  output logic [StepW-1:0] step_o,
  output logic             halt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_o <= '0;
      halt_o <= 1'b0;
    end else if (!halt_o) begin
      if (hlt_i)      halt_o <= 1'b1;
      else if (clr_i) step_o <= '0;
      else            step_o <= step_o + StepW'(1);
    end
  end
endmodule

// File: rtl/mcode_seq.sv
module mcode_seq
  import mseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   opcode_i,
  output logic [CW_W-1:0]   ctrl_o,
  output logic [STEP_W-1:0] step_o,
  output logic              halt_o
);
  dec_t            dec;
  logic [CW_W-1:0] raw_cw;

  mseq_decode #(.OpW(OP_W)) u_dec (
    .opcode_i (opcode_i),
    .dec_o    (dec)
  );

  mseq_ucode #(.StepW(STEP_W), .CwW(CW_W)) u_ucode (
    .dec_i  (dec),
    .step_i (step_o),
    .cw_o   (raw_cw)
  );

  mseq_step_ctr #(.StepW(STEP_W)) u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (raw_cw[B_RSC]),
    .hlt_i  (raw_cw[B_HLT]),
    .step_o (step_o),
    .halt_o (halt_o)
  );

  assign ctrl_o = halt_o ? '0 : raw_cw;
endmodule

// File: rtl/mcode_seq_chk.sv
module mcode_seq_chk #(
  parameter int StepW = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [31:0]      ctrl_o,
  input logic [StepW-1:0] step_o,
  input logic             halt_o
);
  AST_FETCH_STEP0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && step_o == '0) |-> ctrl_o == 32'h9000_0000); // R2
  AST_ONE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_o[31], ctrl_o[26], ctrl_o[24], ctrl_o[22], ctrl_o[20:12]})); // R4
  AST_STEP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && ctrl_o[1] && !ctrl_o[0]) |=> step_o == '0); // R3
  AST_STEP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && !ctrl_o[1] && !ctrl_o[0]) |=> step_o == StepW'($past(step_o) + 1)); // R3
  AST_HALT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[0] |=> halt_o); // R10
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (halt_o && $stable(step_o))); // R10
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> ctrl_o == '0); // R10
endmodule

bind mcode_seq mcode_seq_chk #(.StepW(mseq_pkg::STEP_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ctrl_o (ctrl_o),
  .step_o (step_o),
  .halt_o (halt_o)
);

// File: tb/mcode_seq_tb.sv
`timescale 1ns/1ps
module mcode_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [31:0] ctrl;
  logic [3:0]  step;
  logic        halt;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mcode_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .opcode_i(opcode),
    .ctrl_o(ctrl), .step_o(step), .halt_o(halt)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s op=%h step=%0d act=%h exp=%h", req, opcode, step, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_cw(input int op, input int s);
    int m;
    if (s == 0) return 32'h9000_0000;
    if (s == 1) return 32'h2C00_0000;
    if (op == 1) return (s == 2) ? 32'h1 : 32'h2;
    if (op >= 2 && op <= 8) begin
      if (s == 2) return 32'hB000_0000;
      return 32'h4400_0002 | ((op == 2) ? 32'h0 : (32'h1 << (10 - op)));
    end
    if (op >= 9 && op <= 14) begin
      m = (op - 9) % 3;
      if (s == 2) return 32'hB000_0000;
      if (s < 3 + m) return 32'h1400_0000;
      return 32'h0400_0002 | ((op <= 11) ? (32'h1 << 23) : (32'h1 << 21));
    end
    if (op >= 15 && op <= 18) begin
      m = 1 + (op - 15) % 2;
      if (s == 2) return 32'hB000_0000;
      if (s < 3 + m) return 32'h1400_0000;
      return 32'h0200_0002 | ((op <= 16) ? (32'h1 << 24) : (32'h1 << 22));
    end
    if (op >= 19 && op <= 27) return (32'h1 << (20 - (op - 19))) | (32'h1 << 23) | 32'h2;
    if (op == 28) return 32'h0008_0002;
    if (op >= 29 && op <= 32) return (32'h1 << 24) | (32'h1 << (11 - (op - 29))) | 32'h2;
    return 32'h2;
  endfunction

  function automatic string req_of(input int op, input int s);
    if (s < 2) return "R2";
    if (op == 1) return "R10";
    if (op >= 2 && op <= 8) return "R5";
    if (op >= 9 && op <= 14) return "R6";
    if (op >= 15 && op <= 18) return "R7";
    if (op >= 19 && op <= 28) return "R8";
    if (op >= 29 && op <= 32) return "R9";
    return "R11";
  endfunction

  initial begin : watchdog
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] e;
    for (int op = 0; op < 256; op++) begin
      @(negedge clk);
      rst_n  = 1'b0;
      opcode = 8'(op);
      #1;
      chk(step == 4'd0 && !halt, "R1", {27'd0, halt, step}, 32'h0);
      chk(ctrl == 32'h9000_0000, "R1", ctrl, 32'h9000_0000);
      @(negedge clk);
      rst_n = 1'b1;
      for (int s = 0; s < 16; s++) begin
        e = exp_cw(op, s);
        chk(step == 4'(s) && !halt, "R3", {27'd0, halt, step}, 32'(s));
        chk(ctrl == e, req_of(op, s), ctrl, e);
        chk($countones({ctrl[31], ctrl[26], ctrl[24], ctrl[22], ctrl[20:12]}) <= 1,
            "R4", ctrl, e);
        @(negedge clk);
        if (e[0]) begin
          for (int k = 0; k < 4; k++) begin
            chk(halt && step == 4'(s), "R10", {27'd0, halt, step}, {27'd1, 1'b1, 4'(s)});
            chk(ctrl == 32'h0, "R10", ctrl, 32'h0);
            @(negedge clk);
          end
          break;
        end
        if (e[1]) begin
          chk(step == 4'd0 && !halt, "R3", {27'd0, halt, step}, 32'h0);
          break;
        end
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule